// File: doc/BRIEF.md
# Coefficient RAM Host Access Controller

This block holds a 62-entry store of 24-bit filter and mixer coefficients and lets a host on an 8-bit register bus reach it only indirectly. The host writes a coefficient index into an index register, places coefficient bytes in a bank of fifteen byte-wide staging registers, and then raises one command bit in a command register. A small sequencer then moves either one coefficient or a five-coefficient filter group between the staging bank and the store, one coefficient per clock cycle. The command bit drops by itself when the move is done.

After reset the store holds its power-up values. The unity-like values sit on the last term of each filter group and on the scale and mix entries, and every other entry is zero. A separate combinational read port lets the signal datapath fetch any coefficient by index at any time.

Register offsets: 0x00 index register (8 bits), 0x01 command register, 0x02–0x10 staging bytes. Coefficient k of a group uses staging bytes 3k, 3k+1 and 3k+2, most significant byte at the lowest offset. Group order is b1, b2, a1, a2, b0.

Top module: `coef_ram_ctrl`

## Requirements
- R1: On reset, entry i of the store is 0x400000 when i < 50 and i mod 5 = 4. Entries 50–54, 56 and 59 are 0x7FFFFF. Entry 55 is 0x5A9DF7, entries 60 and 61 are 0x400000, and all others are 0. Reset also clears the index register, the command register and all staging bytes.
- R2: The index register (offset 0x00) and the staging bytes (0x02–0x10) read back the last byte the host wrote to them.
- R3: Command bit 0 (value 0x01) copies staging bytes 0x02, 0x03, 0x04 as {MSB, mid, LSB} into the entry named by the index register.
- R4: Command bit 1 (0x02) copies staging coefficients 0..4 into entries index..index+4, in that order. Entries outside that range are left unchanged.
- R5: Command bit 2 (0x04) copies the entry named by the index register into staging bytes 0x02–0x04, MSB first.
- R6: Command bit 3 (0x08) copies entries index..index+4 into staging coefficients 0..4.
- R7: The command bit in the low nibble of 0x01 reads back as set while its transfer runs and reads as zero once it has finished, at most 7 cycles after the write.
- R8: The upper nibble of 0x01 holds the value last written to it, and the self-clearing of the command bit does not change it.
- R9: A write to 0x01 with a zero low nibble starts no transfer. The store and the staging bytes are left unchanged.
- R10: In a five-coefficient transfer, positions whose index would exceed 61 are skipped. A write leaves the store unchanged there, and a read leaves those staging bytes unchanged.
- R11: If several command bits are set in one write, only the lowest-numbered one is executed.
- R12: `dsp_coef` shows store entry `dsp_idx` in the same cycle, and shows 0 for an index above 61.
- R13: `rdata` is registered: it updates on the clock edge that samples `rd`, and unmapped offsets (above 0x10) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write byte |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read byte |
| busy | output | 1 | A transfer is in progress |
| dsp_idx | input | 6 | Datapath coefficient index |
| dsp_coef | output | 24 | Datapath coefficient value |

## Verification
The assertions assume that the host never raises `wr` and `rd` in the same cycle. They also assume that while `busy` is high the host leaves the index register and the staging bytes alone and issues no new command. The stimulus keeps to this by making every register access a single strobe cycle. After each command it idles eight cycles, which is longer than the longest transfer. Commands that arrive while a transfer runs are dropped by the design, and the sequences never produce them.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int REG_IDX    = 0;
  localparam int REG_CMD    = 1;
  localparam int REG_STAGE0 = 2;

  // power-up content of one store entry
  function automatic logic [23:0] coef_reset_val(input int i);
    logic [23:0] v;
    v = 24'h000000;
    if (i < 50 && (i % 5) == 4)                 v = 24'h400000;
    if ((i >= 50 && i <= 54) || i == 56 || i == 59) v = 24'h7FFFFF;
    if (i == 55)                                v = 24'h5A9DF7;
    if (i == 60 || i == 61)                     v = 24'h400000;
    return v;
  endfunction
endpackage

// File: rtl/coef_store.sv
module coef_store #(
  parameter int N_COEF = 62,
  parameter int COEF_W = 24,
  localparam int IDX_W = $clog2(N_COEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [COEF_W-1:0] wdata_i,
  output logic [COEF_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  dsp_idx_i,
  output logic [COEF_W-1:0] dsp_coef_o
);
  logic [COEF_W-1:0] mem_q [N_COEF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_COEF; i++) mem_q[i] <= COEF_W'(coef_pkg::coef_reset_val(i));
    end else if (we_i && (int'(idx_i) < N_COEF)) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o    = (int'(idx_i) < N_COEF) ? mem_q[idx_i] : '0;
    dsp_coef_o = (int'(dsp_idx_i) < N_COEF) ? mem_q[dsp_idx_i] : '0;
  end

  // the sequencer must never write past the last entry
  assert_we_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (int'(idx_i) < N_COEF));
endmodule

// File: rtl/coef_xfer_seq.sv
module coef_xfer_seq #(
  parameter int N_COEF = 62,
  parameter int COEF_W = 24,
  parameter int GROUP  = 5,
  parameter int REG_DW = 8,
  localparam int IDX_W = $clog2(N_COEF),
  localparam int KW    = $clog2(GROUP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [3:0]              cmd_i,
  input  logic [REG_DW-1:0]       base_i,
  input  logic [GROUP*COEF_W-1:0] stage_coef_i,
  input  logic [COEF_W-1:0]       ram_rdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    ram_we_o,
  output logic [IDX_W-1:0]        ram_idx_o,
  output logic [COEF_W-1:0]       ram_wdata_o,
  output logic                    st_we_o,
  output logic [KW-1:0]           st_k_o,
  output logic [COEF_W-1:0]       st_data_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state_q;
  logic [REG_DW-1:0] base_q;
  logic [KW-1:0]     k_q;
  logic              is_wr_q, is_five_q;
  logic [REG_DW:0]   cur;
  logic              in_range, last;

  assign cur      = {1'b0, base_q} + (REG_DW+1)'(k_q);
  assign in_range = int'(cur) < N_COEF;
  assign last     = is_five_q ? (k_q == KW'(GROUP-1)) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE; base_q <= '0; k_q <= '0; is_wr_q <= 1'b0; is_five_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q   <= S_RUN;
          base_q    <= base_i;
          k_q       <= '0;
          is_wr_q   <= cmd_i[0] | cmd_i[1];
          is_five_q <= cmd_i[1] | cmd_i[3];
        end
        S_RUN: begin
          k_q <= k_q + 1'b1;
          if (last) state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o      = state_q != S_IDLE;
    done_o      = state_q == S_FIN;
    ram_idx_o   = cur[IDX_W-1:0];
    ram_we_o    = (state_q == S_RUN) && is_wr_q && in_range;
    st_we_o     = (state_q == S_RUN) && !is_wr_q && in_range;
    st_k_o      = k_q;
    st_data_o   = ram_rdata_i;
    ram_wdata_o = stage_coef_i[int'(k_q)*COEF_W +: COEF_W];
  end

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: rtl/coef_host_regs.sv
module coef_host_regs #(
  parameter int COEF_W = 24,
  parameter int GROUP  = 5,
  parameter int REG_AW = 8,
  parameter int REG_DW = 8,
  localparam int BPC     = COEF_W / REG_DW,
  localparam int STAGE_N = GROUP * BPC,
  localparam int KW      = $clog2(GROUP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [REG_AW-1:0]       addr_i,
  input  logic [REG_DW-1:0]       wdata_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  output logic [REG_DW-1:0]       rdata_o,
  input  logic                    busy_i,
  input  logic                    done_i,
  input  logic                    st_we_i,
  input  logic [KW-1:0]           st_k_i,
  input  logic [COEF_W-1:0]       st_data_i,
  output logic                    start_o,
  output logic [3:0]              cmd_o,
  output logic [REG_DW-1:0]       base_o,
  output logic [GROUP*COEF_W-1:0] stage_coef_o
);
  import coef_pkg::*;
  logic [REG_DW-1:0] idx_q, rdata_q, rd_sel;
  logic [3:0]        cmd_q, rsv_q, low;
  logic [REG_DW-1:0] stage_q [STAGE_N];
  logic              cmd_wr;

  assign cmd_wr  = wr_i && (int'(addr_i) == REG_CMD);
  assign low     = wdata_i[3:0] & (~wdata_i[3:0] + 4'd1);
  assign start_o = cmd_wr && (wdata_i[3:0] != 4'd0) && !busy_i;
  assign cmd_o   = low;
  assign base_o  = idx_q;
  assign rdata_o = rdata_q;

  for (genvar k = 0; k < GROUP; k++) begin : g_pack
    for (genvar b = 0; b < BPC; b++) begin : g_byte
      assign stage_coef_o[k*COEF_W + (BPC-1-b)*REG_DW +: REG_DW] = stage_q[k*BPC + b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; cmd_q <= '0; rsv_q <= '0;
      for (int j = 0; j < STAGE_N; j++) stage_q[j] <= '0;
    end else begin
      if (wr_i && int'(addr_i) == REG_IDX) idx_q <= wdata_i;
      if (cmd_wr) rsv_q <= wdata_i[7:4];
      if (done_i)       cmd_q <= '0;
      else if (start_o) cmd_q <= low;
      for (int j = 0; j < STAGE_N; j++) begin
        if (st_we_i && (j / BPC) == int'(st_k_i))
          stage_q[j] <= st_data_i[(BPC-1-(j % BPC))*REG_DW +: REG_DW];
        else if (wr_i && int'(addr_i) == REG_STAGE0 + j)
          stage_q[j] <= wdata_i;
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    if (int'(addr_i) == REG_IDX) rd_sel = idx_q;
    if (int'(addr_i) == REG_CMD) rd_sel = {rsv_q, cmd_q};
    for (int j = 0; j < STAGE_N; j++)
      if (int'(addr_i) == REG_STAGE0 + j) rd_sel = stage_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_sel;
  end

  assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> $onehot(cmd_q));
  assert_cmd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (cmd_q == 4'd0));
  assert_rsv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(rsv_q));
  assert_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata_i[3:0] == 4'd0 && !busy_i) |=> !busy_i);
endmodule

// File: rtl/coef_ram_ctrl.sv
module coef_ram_ctrl #(
  parameter int N_COEF = 62,
  parameter int COEF_W = 24,
  parameter int GROUP  = 5,
  parameter int REG_AW = 8,
  parameter int REG_DW = 8,
  localparam int IDX_W = $clog2(N_COEF),
  localparam int KW    = $clog2(GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [REG_DW-1:0] rdata,
  output logic              busy,
  input  logic [IDX_W-1:0]  dsp_idx,
  output logic [COEF_W-1:0] dsp_coef
);
  logic                    start, done, ram_we, st_we;
  logic [3:0]              cmd;
  logic [REG_DW-1:0]       base;
  logic [GROUP*COEF_W-1:0] stage_coef;
  logic [IDX_W-1:0]        ram_idx;
  logic [COEF_W-1:0]       ram_wdata, ram_rdata, st_data;
  logic [KW-1:0]           st_k;

  coef_host_regs #(.COEF_W(COEF_W), .GROUP(GROUP), .REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .busy_i(busy), .done_i(done), .st_we_i(st_we), .st_k_i(st_k),
    .st_data_i(st_data), .start_o(start), .cmd_o(cmd), .base_o(base),
    .stage_coef_o(stage_coef));

  coef_xfer_seq #(.N_COEF(N_COEF), .COEF_W(COEF_W), .GROUP(GROUP), .REG_DW(REG_DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .base_i(base),
    .stage_coef_i(stage_coef), .ram_rdata_i(ram_rdata), .busy_o(busy), .done_o(done),
    .ram_we_o(ram_we), .ram_idx_o(ram_idx), .ram_wdata_o(ram_wdata), .st_we_o(st_we),
    .st_k_o(st_k), .st_data_o(st_data));

  coef_store #(.N_COEF(N_COEF), .COEF_W(COEF_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(ram_we), .idx_i(ram_idx), .wdata_i(ram_wdata),
    .rdata_o(ram_rdata), .dsp_idx_i(dsp_idx), .dsp_coef_o(dsp_coef));
endmodule

// File: tb/sim_coef_ram_ctrl.sv
module sim_coef_ram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;
  // entry: op[37:36] (0 write, 1 read-check, 2 wait, 3 datapath-check), addr, data/expect, requirement
  localparam logic [37:0] VEC [NV] = '{
    {2'd1, 8'h00, 24'h000000, 4'd2},   // R2 index resets to 0
    {2'd1, 8'h01, 24'h000000, 4'd7},   // R7 command reg resets to 0
    {2'd3, 8'h04, 24'h400000, 4'd1},   // R1
    {2'd3, 8'h37, 24'h5A9DF7, 4'd1},   // R1 entry 55
    {2'd3, 8'h3C, 24'h400000, 4'd1},   // R1 entry 60
    {2'd3, 8'h00, 24'h000000, 4'd1},   // R1 entry 0
    {2'd3, 8'h38, 24'h7FFFFF, 4'd1},   // R1 entry 56
    {2'd3, 8'h3E, 24'h000000, 4'd12},  // R12 beyond last entry
    {2'd0, 8'h00, 24'h000009, 4'd2},
    {2'd1, 8'h00, 24'h000009, 4'd2},   // R2
    {2'd0, 8'h01, 24'h000004, 4'd5},   // read one at 9
    {2'd2, 8'h00, 24'h000000, 4'd0},
    {2'd1, 8'h02, 24'h000040, 4'd5},   // R5
    {2'd1, 8'h03, 24'h000000, 4'd5},
    {2'd1, 8'h04, 24'h000000, 4'd5},
    {2'd0, 8'h00, 24'h000032, 4'd6},
    {2'd0, 8'h01, 24'h000008, 4'd6},   // read five at 50
    {2'd2, 8'h00, 24'h000000, 4'd0},
    {2'd1, 8'h02, 24'h00007F, 4'd6},   // R6
    {2'd1, 8'h04, 24'h0000FF, 4'd6},
    {2'd1, 8'h0E, 24'h00007F, 4'd6},
    {2'd1, 8'h10, 24'h0000FF, 4'd6},
    {2'd0, 8'h02, 24'h000012, 4'd3},
    {2'd0, 8'h03, 24'h000034, 4'd3},
    {2'd0, 8'h04, 24'h000056, 4'd3},
    {2'd0, 8'h00, 24'h000007, 4'd3},
    {2'd0, 8'h01, 24'h000001, 4'd3},   // write one at 7
    {2'd2, 8'h00, 24'h000000, 4'd0},
    {2'd3, 8'h07, 24'h123456, 4'd3},   // R3
    {2'd0, 8'h02, 24'h000000, 4'd5},
    {2'd0, 8'h01, 24'h000004, 4'd5},   // read back entry 7
    {2'd2, 8'h00, 24'h000000, 4'd0},
    {2'd1, 8'h02, 24'h000012, 4'd5},   // R5
    {2'd1, 8'h04, 24'h000056, 4'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic busy;
  logic [5:0] dsp_idx = '0;
  logic [23:0] dsp_coef;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_ram_ctrl u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .busy(busy), .dsp_idx(dsp_idx), .dsp_coef(dsp_coef));

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic dsp_get(input logic [5:0] i, output logic [23:0] v);
    @(negedge clk); dsp_idx = i; #1 v = dsp_coef;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [23:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < NV; n++) begin
      logic [37:0] v;
      v = VEC[n];
      case (v[37:36])
        2'd0: wr_reg(v[35:28], v[11:4]);
        2'd1: begin rd_reg(v[35:28], r); check($sformatf("R%0d reg %h", v[3:0], v[35:28]), {16'd0, r}, {16'd0, v[11:4]}); end
        2'd2: settle();
        default: begin dsp_get(v[33:28], c); check($sformatf("R%0d dsp %0d", v[3:0], v[33:28]), c, v[27:4]); end
      endcase
    end

    // R4 write five at 10, staging byte j = A0+j
    for (int j = 0; j < 15; j++) wr_reg(8'(2 + j), 8'(8'hA0 + j));
    wr_reg(8'h00, 8'd10); wr_reg(8'h01, 8'h02); settle();
    for (int k = 0; k < 5; k++) begin
      dsp_get(6'(10 + k), c);
      check("R4 group write", c, {8'(8'hA0+3*k), 8'(8'hA1+3*k), 8'(8'hA2+3*k)});
    end
    dsp_get(6'd15, c); check("R4 neighbour untouched", c, 24'h000000);
    dsp_get(6'd9, c);  check("R4 neighbour untouched", c, 24'h400000);

    // R10 write five at 59 only fills 59..61
    wr_reg(8'h00, 8'd59); wr_reg(8'h01, 8'h02); settle();
    dsp_get(6'd59, c); check("R10 wr 59", c, 24'hA0A1A2);
    dsp_get(6'd60, c); check("R10 wr 60", c, 24'hA3A4A5);
    dsp_get(6'd61, c); check("R10 wr 61", c, 24'hA6A7A8);
    dsp_get(6'd58, c); check("R10 wr 58", c, 24'h000000);

    // R10 read five at 60: staging coefficient 2 left as is
    wr_reg(8'h08, 8'h55); wr_reg(8'h00, 8'd60); wr_reg(8'h01, 8'h08); settle();
    rd_reg(8'h02, r); check("R10 rd byte0", {16'd0, r}, 24'h0000A3);
    rd_reg(8'h05, r); check("R10 rd byte3", {16'd0, r}, 24'h0000A6);
    rd_reg(8'h08, r); check("R10 rd byte6 kept", {16'd0, r}, 24'h000055);

    // R11 bits 0 and 2 together: write one wins
    wr_reg(8'h00, 8'd4); wr_reg(8'h02, 8'h99); wr_reg(8'h03, 8'h88); wr_reg(8'h04, 8'h77);
    wr_reg(8'h01, 8'h05); settle();
    dsp_get(6'd4, c); check("R11 lowest bit ran", c, 24'h998877);
    rd_reg(8'h02, r); check("R11 read not run", {16'd0, r}, 24'h000099);

    // R7 / R8 command readback while running and after
    wr_reg(8'h00, 8'd0); wr_reg(8'h01, 8'hA8);
    rd_reg(8'h01, r); check("R7 bit set while busy", {16'd0, r}, 24'h0000A8);
    settle();
    rd_reg(8'h01, r); check("R8 upper kept, R7 cleared", {16'd0, r}, 24'h0000A0);

    // R9 zero command nibble
    wr_reg(8'h00, 8'd4); wr_reg(8'h01, 8'h50); settle();
    rd_reg(8'h02, r); check("R9 staging untouched", {16'd0, r}, 24'h000000);
    dsp_get(6'd4, c); check("R9 store untouched", c, 24'h998877);
    rd_reg(8'h01, r); check("R9 readback", {16'd0, r}, 24'h000050);

    // R13 unmapped offset
    wr_reg(8'h20, 8'h3C);
    rd_reg(8'h20, r); check("R13 unmapped", {16'd0, r}, 24'h000000);

    // R1 reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    dsp_get(6'd4, c); check("R1 reset entry 4", c, 24'h400000);
    dsp_get(6'd7, c); check("R1 reset entry 7", c, 24'h000000);
    rd_reg(8'h01, r); check("R1 reset cmd reg", {16'd0, r}, 24'h000000);
    rd_reg(8'h02, r); check("R1 reset staging", {16'd0, r}, 24'h000000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule